// File: doc/BRIEF.md
# Halted-CPU Screen Memory Copy Engine

This block refreshes a local video buffer from screen memory kept in an external SRAM that a host CPU also uses. The host CPU has a fully static core, so its clock can be stopped in any phase and restarted later without losing state. The engine needs no dual-port memory and does not interleave its cycles with the CPU's. Instead it runs short exclusive bursts. On a line strobe it stops the CPU clock and tri-states the CPU bus. It waits for the bus to settle, then reads a block of bytes from SRAM and writes them into the local buffer. It then gives the bus back and restarts the clock.

A frame strobe marks vertical sync and samples the source base address. Each of the first `BURSTS` line strobes after it runs one burst of `BURST_LEN` bytes. With the defaults that is 13 bursts of 128 bytes, or 1664 bytes per frame, filling buffer addresses 0 to 1663. Within a burst only the low address byte advances, so the SRAM page stays fixed. Every byte is read with `WAIT_CYC` extra wait cycles, which lets the engine work with slow memory. A whole burst takes 4 + `SETTLE_CYC` + `BURST_LEN`×(`WAIT_CYC`+1) cycles. This must fit within one display line.

Top module: `scrcopy_engine`

## Requirements
- R1: After reset `cpu_clk_en`=1, `cpu_be`=1, `sram_ce_n`=1, `sram_addr_oe`=0 and `buf_we`=0. Line strobes start no burst until the first frame strobe.
- R2: After a frame strobe, each of the first `BURSTS` line strobes starts a burst. Later line strobes leave `cpu_clk_en` and `cpu_be` high until the next frame strobe.
- R3: Each burst performs exactly `BURST_LEN` buffer writes. Across a frame the buffer address runs 0,1,2,… without gaps, and it returns to 0 after a frame strobe.
- R4: `cpu_clk_en` goes low in the cycle after an accepted line strobe. `cpu_be` goes low one cycle later, and `cpu_be` is never low while the clock runs.
- R5: `sram_addr_oe` rises, together with `sram_ce_n` falling, only after `cpu_be` has been low for `SETTLE_CYC` full cycles.
- R6: Each source address is held for `WAIT_CYC`+1 cycles. The byte is captured from `sram_rdata` at the end of that window.
- R7: Burst k of a frame reads from the base address sampled at the frame strobe plus k×`BURST_LEN`.
- R8: Within a burst only the low 8 address bits increment. They wrap from 0xFF to 0x00 while the upper bits stay unchanged.
- R9: One cycle after the last capture, `sram_ce_n` is high and `sram_addr_oe` is low. `cpu_be` rises one cycle later, and `cpu_clk_en` rises one cycle after that.
- R10: Line strobes that arrive while a burst is running are ignored and not queued.
- R11: A frame strobe between bursts restarts the frame at once. A frame strobe during a burst lets that burst finish unchanged, and then restarts the frame.
- R12: `sram_addr_oe` is never high while `cpu_be` is high.
- R13: Each captured byte appears for one cycle as `buf_we`=1, with `buf_wdata` set to the byte and `buf_addr` set to its buffer position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle vertical sync marker |
| line_stb | input | 1 | One-cycle line start marker |
| scr_base | input | SRAM_AW | Source base address, sampled on frame_stb |
| cpu_clk_en | output | 1 | CPU clock gate, 1 = clock runs |
| cpu_be | output | 1 | CPU bus enable, active high |
| sram_addr | output | SRAM_AW | SRAM address driven by the engine |
| sram_addr_oe | output | 1 | Engine drives the SRAM address lines |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_rdata | input | DATA_W | SRAM read data |
| buf_we | output | 1 | Local buffer write strobe |
| buf_addr | output | BUF_AW | Local buffer write address |
| buf_wdata | output | DATA_W | Local buffer write data |

## Verification
The bench builds the engine with `BURST_LEN`=16, `BURSTS`=3, `SETTLE_CYC`=3 and `WAIT_CYC`=1. This keeps each frame short, so several frames fit into one run, including frame strobes both between bursts and inside a burst. A base address ending in 0xF8 makes the first burst cross the low-byte wrap, which exposes any carry into the page bits. The SRAM model returns a poison value until an address has been stable for one cycle, so a missing wait cycle shows up as wrong buffer data.

// File: rtl/scrcopy_pkg.sv
package scrcopy_pkg;
  typedef enum logic [2:0] {
    CP_IDLE,
    CP_STOP,
    CP_SETTLE,
    CP_XFER,
    CP_BUSOFF,
    CP_RESUME
  } cp_state_t;
endpackage

// File: rtl/scrcopy_ctrl.sv
module scrcopy_ctrl
  import scrcopy_pkg::*;
#(
  parameter int BURST_LEN  = 128,
  parameter int BURSTS     = 13,
  parameter int SETTLE_CYC = 2,
  parameter int WAIT_CYC   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic line_stb,
  output logic clk_en,
  output logic bus_en,
  output logic ce_n,
  output logic addr_oe,
  output logic frame_apply,
  output logic burst_load,
  output logic byte_adv
);
  localparam int SC_W   = $clog2(SETTLE_CYC + 1);
  localparam int WC_W   = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam int BI_W   = $clog2(BURST_LEN);
  localparam int LEFT_W = $clog2(BURSTS + 1);

  cp_state_t          st;
  logic               pend;
  logic [SC_W-1:0]    sc;
  logic [WC_W-1:0]    wc;
  logic [BI_W-1:0]    bi;
  logic [LEFT_W-1:0]  left;
  logic               last_byte;

  always_comb begin
    frame_apply = (st == CP_IDLE) && (frame_stb || pend);
    burst_load  = (st == CP_SETTLE) && (sc == SC_W'(SETTLE_CYC - 1));
    byte_adv    = (st == CP_XFER) && (wc == WC_W'(WAIT_CYC));
    last_byte   = byte_adv && (bi == BI_W'(BURST_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CP_IDLE;
      pend    <= 1'b0;
      left    <= '0;
      sc      <= '0;
      wc      <= '0;
      bi      <= '0;
      clk_en  <= 1'b1;
      bus_en  <= 1'b1;
      ce_n    <= 1'b1;
      addr_oe <= 1'b0;
    end else begin
      if (frame_apply)    pend <= 1'b0;
      else if (frame_stb) pend <= 1'b1;
      case (st)
        CP_IDLE: begin
          if (frame_apply) begin
            left <= LEFT_W'(BURSTS);
          end else if (line_stb && left != '0) begin
            clk_en <= 1'b0;
            st     <= CP_STOP;
          end
        end
        CP_STOP: begin
          bus_en <= 1'b0;
          sc     <= '0;
          st     <= CP_SETTLE;
        end
        CP_SETTLE: begin
          if (burst_load) begin
            addr_oe <= 1'b1;
            ce_n    <= 1'b0;
            wc      <= '0;
            bi      <= '0;
            st      <= CP_XFER;
          end else begin
            sc <= sc + 1'b1;
          end
        end
        CP_XFER: begin
          if (byte_adv) begin
            wc <= '0;
            bi <= bi + 1'b1;
            if (last_byte) begin
              addr_oe <= 1'b0;
              ce_n    <= 1'b1;
              st      <= CP_BUSOFF;
            end
          end else begin
            wc <= wc + 1'b1;
          end
        end
        CP_BUSOFF: begin
          bus_en <= 1'b1;
          st     <= CP_RESUME;
        end
        CP_RESUME: begin
          clk_en <= 1'b1;
          left   <= left - 1'b1;
          st     <= CP_IDLE;
        end
        default: st <= CP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scrcopy_addr.sv
module scrcopy_addr #(
  parameter int SRAM_AW   = 16,
  parameter int PAGE_BITS = 8,
  parameter int BURST_LEN = 128,
  parameter int BUF_AW    = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_stb,
  input  logic               frame_apply,
  input  logic [SRAM_AW-1:0] scr_base,
  input  logic               burst_load,
  input  logic               byte_adv,
  output logic [SRAM_AW-1:0] src_addr,
  output logic [BUF_AW-1:0]  dst_addr
);
  localparam int HI_W = SRAM_AW - PAGE_BITS;

  logic [SRAM_AW-1:0]   base_q;
  logic [SRAM_AW-1:0]   blk;
  logic [PAGE_BITS-1:0] lo_next;

  always_comb lo_next = src_addr[PAGE_BITS-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      blk      <= '0;
      src_addr <= '0;
      dst_addr <= '0;
    end else begin
      if (frame_stb) base_q <= scr_base;
      if (frame_apply) begin
        blk      <= frame_stb ? scr_base : base_q;
        dst_addr <= '0;
      end
      if (burst_load) begin
        src_addr <= blk;
        blk      <= blk + SRAM_AW'(BURST_LEN);
      end
      if (byte_adv) begin
        src_addr <= {src_addr[SRAM_AW-1:SRAM_AW-HI_W], lo_next};
        dst_addr <= dst_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scrcopy_engine.sv
module scrcopy_engine #(
  parameter int SRAM_AW    = 16,
  parameter int DATA_W     = 8,
  parameter int BURST_LEN  = 128,
  parameter int BURSTS     = 13,
  parameter int SETTLE_CYC = 2,
  parameter int WAIT_CYC   = 1,
  localparam int BUF_AW    = $clog2(BURSTS * BURST_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_stb,
  input  logic               line_stb,
  input  logic [SRAM_AW-1:0] scr_base,
  output logic               cpu_clk_en,
  output logic               cpu_be,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_addr_oe,
  output logic               sram_ce_n,
  input  logic [DATA_W-1:0]  sram_rdata,
  output logic               buf_we,
  output logic [BUF_AW-1:0]  buf_addr,
  output logic [DATA_W-1:0]  buf_wdata
);
  logic              frame_apply;
  logic              burst_load;
  logic              byte_adv;
  logic [BUF_AW-1:0] dst_addr;

  scrcopy_ctrl #(
    .BURST_LEN (BURST_LEN),
    .BURSTS    (BURSTS),
    .SETTLE_CYC(SETTLE_CYC),
    .WAIT_CYC  (WAIT_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .line_stb   (line_stb),
    .clk_en     (cpu_clk_en),
    .bus_en     (cpu_be),
    .ce_n       (sram_ce_n),
    .addr_oe    (sram_addr_oe),
    .frame_apply(frame_apply),
    .burst_load (burst_load),
    .byte_adv   (byte_adv)
  );

  scrcopy_addr #(
    .SRAM_AW  (SRAM_AW),
    .PAGE_BITS(8),
    .BURST_LEN(BURST_LEN),
    .BUF_AW   (BUF_AW)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .frame_apply(frame_apply),
    .scr_base   (scr_base),
    .burst_load (burst_load),
    .byte_adv   (byte_adv),
    .src_addr   (sram_addr),
    .dst_addr   (dst_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= byte_adv;
      if (byte_adv) begin
        buf_addr  <= dst_addr;
        buf_wdata <= sram_rdata;
      end
    end
  end
endmodule

// File: rtl/scrcopy_engine_chk.sv
module scrcopy_engine_chk #(
  parameter int SETTLE_CYC = 2,
  parameter int AW         = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_clk_en,
  input logic          cpu_be,
  input logic          sram_ce_n,
  input logic          sram_addr_oe,
  input logic [AW-1:0] sram_addr,
  input logic          buf_we
);
  logic [7:0] be_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   be_low_cnt <= '0;
    else if (cpu_be)           be_low_cnt <= '0;
    else if (be_low_cnt != '1) be_low_cnt <= be_low_cnt + 1'b1;
  end

  AST_SETTLE_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_addr_oe) |-> be_low_cnt >= 8'(SETTLE_CYC)); // R5

  AST_NO_DRIVE_WITH_CPU: assert property (@(posedge clk) disable iff (rst)
    sram_addr_oe |-> !cpu_be); // R12

  AST_BUS_OFF_CLOCK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !cpu_be |-> !cpu_clk_en); // R4

  AST_STOP_BEFORE_BUSOFF: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_be) |-> (!cpu_clk_en && !$past(cpu_clk_en))); // R4

  AST_BUSON_BEFORE_RESUME: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> (cpu_be && $past(cpu_be))); // R9

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (sram_addr_oe && $past(sram_addr_oe)) |-> (sram_addr[AW-1:8] == $past(sram_addr[AW-1:8]))); // R8

  AST_WRITE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !$past(sram_ce_n)); // R13
endmodule

bind scrcopy_engine scrcopy_engine_chk #(
  .SETTLE_CYC(SETTLE_CYC),
  .AW        (SRAM_AW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_clk_en  (cpu_clk_en),
  .cpu_be      (cpu_be),
  .sram_ce_n   (sram_ce_n),
  .sram_addr_oe(sram_addr_oe),
  .sram_addr   (sram_addr),
  .buf_we      (buf_we)
);

// File: tb/scrcopy_engine_test.sv
`timescale 1ns/1ps
module scrcopy_engine_test;
  localparam int AW  = 16;
  localparam int BL  = 16;
  localparam int NB  = 3;
  localparam int SET = 3;
  localparam int WT  = 1;
  localparam int BAW = $clog2(NB * BL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic line_stb = 1'b0;
  logic [AW-1:0] scr_base = '0;
  logic cpu_clk_en, cpu_be, sram_addr_oe, sram_ce_n, buf_we;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_rdata, buf_wdata;
  logic [BAW-1:0] buf_addr;

  always #5 clk = ~clk;

  scrcopy_engine #(
    .SRAM_AW(AW), .DATA_W(8), .BURST_LEN(BL), .BURSTS(NB),
    .SETTLE_CYC(SET), .WAIT_CYC(WT)
  ) uut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .line_stb(line_stb),
    .scr_base(scr_base), .cpu_clk_en(cpu_clk_en), .cpu_be(cpu_be),
    .sram_addr(sram_addr), .sram_addr_oe(sram_addr_oe), .sram_ce_n(sram_ce_n),
    .sram_rdata(sram_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] + a[15:8] * 8'd7;
  endfunction

  // slow SRAM model: data valid only once the address has been stable a cycle
  logic        drive;
  logic [15:0] prev_a;
  int          stable;
  assign drive = !sram_ce_n && sram_addr_oe;
  always @(posedge clk) begin
    if (drive) stable <= (sram_addr == prev_a) ? stable + 1 : 1;
    else       stable <= 0;
    prev_a <= sram_addr;
  end
  assign sram_rdata = (drive && stable >= WT) ? memf(sram_addr) : 8'hEE;

  // scoreboard
  logic [BAW+7:0] sbq[$];
  logic [15:0] m_blk;
  int m_dst;
  int m_left = 0;

  task automatic model_frame(input logic [15:0] base);
    m_blk = base; m_dst = 0; m_left = NB;
  endtask

  task automatic model_line();
    logic [15:0] a;
    if (m_left > 0) begin
      for (int i = 0; i < BL; i++) begin
        a = {m_blk[15:8], m_blk[7:0] + 8'(i)};
        sbq.push_back({BAW'(m_dst), memf(a)});
        m_dst++;
      end
      m_blk += 16'(BL);
      m_left--;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && buf_we) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R13 unexpected write", buf_addr, 0);
      end else begin
        logic [BAW+7:0] e;
        e = sbq.pop_front();
        check({buf_addr, buf_wdata} == e, "R3/R6/R7/R8/R13 buffer write",
              {buf_addr, buf_wdata}, e);
      end
    end
  end

  task automatic pulse_frame(input logic [15:0] base);
    @(negedge clk); scr_base = base; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_stb = 1'b1;
    @(negedge clk); line_stb = 1'b0;
  endtask

  task automatic line_plain();
    model_line();
    pulse_line();
    repeat (78) @(negedge clk);
  endtask

  task automatic line_timed();
    model_line();
    pulse_line();
    check(!cpu_clk_en && cpu_be, "R4 clock stops first", {cpu_clk_en, cpu_be}, 2'b01);
    @(negedge clk);
    check(!cpu_be && !sram_addr_oe, "R4 bus enable drops next", {cpu_be, sram_addr_oe}, 2'b00);
    for (int i = 0; i < SET - 1; i++) begin
      @(negedge clk);
      check(!sram_addr_oe && sram_ce_n, "R5 settle no drive", {sram_addr_oe, sram_ce_n}, 2'b01);
    end
    @(negedge clk);
    check(sram_addr_oe && !sram_ce_n, "R5 drive after settle", {sram_addr_oe, sram_ce_n}, 2'b10);
    repeat (BL * (WT + 1) - 1) @(negedge clk);
    check(sram_addr_oe, "R6 drive held for all bytes", sram_addr_oe, 1);
    @(negedge clk);
    check(!sram_addr_oe && sram_ce_n && !cpu_be, "R9 release memory",
          {sram_addr_oe, sram_ce_n, cpu_be}, 3'b010);
    @(negedge clk);
    check(cpu_be && !cpu_clk_en, "R9 bus back", {cpu_be, cpu_clk_en}, 2'b10);
    @(negedge clk);
    check(cpu_clk_en, "R9 clock resumes", cpu_clk_en, 1);
    repeat (36) @(negedge clk);
  endtask

  task automatic line_none(input string tag);
    pulse_line();
    for (int i = 0; i < 10; i++) begin
      check(cpu_clk_en && cpu_be, tag, {cpu_clk_en, cpu_be}, 2'b11);
      @(negedge clk);
    end
    repeat (68) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_clk_en && cpu_be && sram_ce_n && !sram_addr_oe && !buf_we, "R1 reset state",
          {cpu_clk_en, cpu_be, sram_ce_n, sram_addr_oe, buf_we}, 5'b11100);
    line_none("R1 no burst before frame");

    // frame A: base crossing the low-byte wrap
    pulse_frame(16'h12F8); model_frame(16'h12F8);
    repeat (5) @(negedge clk);
    line_timed();
    // R10: extra strobe inside the burst is dropped
    model_line();
    pulse_line();
    repeat (18) @(negedge clk);
    line_stb = 1'b1; @(negedge clk); line_stb = 1'b0;
    repeat (40) @(negedge clk);
    check(cpu_clk_en && cpu_be, "R10 mid-burst strobe ignored", {cpu_clk_en, cpu_be}, 2'b11);
    repeat (18) @(negedge clk);
    line_plain();
    line_none("R2 no burst after last");

    // frame B: restart between bursts
    pulse_frame(16'h4000); model_frame(16'h4000);
    repeat (5) @(negedge clk);
    line_plain();
    pulse_frame(16'h0A80); model_frame(16'h0A80);
    repeat (5) @(negedge clk);
    line_plain();
    line_plain();
    line_plain();
    line_none("R2 frame B limit");

    // frame C: restart strobe during a burst (R11)
    pulse_frame(16'h7700); model_frame(16'h7700);
    repeat (5) @(negedge clk);
    model_line();
    pulse_line();
    repeat (20) @(negedge clk);
    pulse_frame(16'h2000);
    model_frame(16'h2000);
    repeat (60) @(negedge clk);
    line_timed();
    line_plain();
    line_plain();
    line_none("R11 restarted frame limit");
    repeat (20) @(negedge clk);
    check(sbq.size() == 0, "R3 all expected writes seen", sbq.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule